// File: doc/BRIEF.md
# Strict Lane-Ordered Coalescing Checker

This block looks at the memory requests of one group of 16 threads and decides whether the whole group can be served by a single aligned memory transaction. The rule is strict. Each participating thread k must address the k-th element slot of one segment. The segment spans 16 elements and sits at an address that is a multiple of its own size. Lanes whose mask bit is clear are left out of the check, so they can neither make nor break the result.

A request is one flat vector of 16 byte addresses (lane 0 in the lowest bits), a 16-bit active mask and a 2-bit element-size code. It enters on a valid/ready handshake. The verdict appears on a registered valid/ready output one clock after acceptance. It states whether the group coalesced, the segment base and transaction size when it did, and a fallback flag when the requester must issue one transaction per active lane instead. Issuing the transactions and moving the data are outside this block.

Back-pressure rules: a request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result stays on the output, unchanged, until it is taken with `out_ready`.

Top module: `hw_coalesce_check`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: Size codes 0, 1 and 2 select element sizes of 4, 8 and 16 bytes. A coalesced result then reports transaction sizes of 64, 128 and 256 bytes. Code 3 never coalesces, and with any active lane it gives fallback=1.
- R3: With a valid size code, the group is coalesced when there is an address B, a multiple of 16 times the element size, such that every active lane k requests exactly B + k × element size. `out_base` then equals B.
- R4: The addresses of lanes whose mask bit is 0 have no effect on the result.
- R5: If any active lane requests an address other than its own slot (displaced, swapped with another lane, or all lanes on one word), the result is coalesced=0 and fallback=1, with `out_base` and `out_bytes` both 0.
- R6: An implied segment base that is not aligned to 16 × element size, or an active address that is not a multiple of the element size, gives coalesced=0 and fallback=1.
- R7: An all-zero mask still produces a result, with coalesced=0, fallback=0, `out_bytes`=0 and `out_base`=0.
- R8: A request accepted on one edge produces `out_valid` on the next edge. While `out_ready` is low, `out_valid` and all result fields hold steady and `in_ready` is low. With `out_ready` high and no new request, `out_valid` drops after one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_addr | input | 512 | 16 byte addresses, lane k at bits [32k+31:32k] |
| in_mask | input | 16 | Active lanes, bit k for lane k |
| in_size | input | 2 | Element-size code (0: 4 B, 1: 8 B, 2: 16 B, 3: unsupported) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result taken this cycle |
| out_coalesced | output | 1 | Group fits one aligned transaction |
| out_fallback | output | 1 | One transaction per active lane is needed |
| out_base | output | 32 | Segment base when coalesced, else 0 |
| out_bytes | output | 9 | Transaction size in bytes when coalesced, else 0 |

## Verification
For each of the three element sizes, the sweep covers every single-lane mask, full, sparse and pseudo-random masks, and several aligned segment bases. Each is paired with a family of address patterns. A perfect pattern with garbage in the inactive lanes separates true masking from checking every lane. Displaced, swapped and broadcast patterns separate per-slot matching from a range test. Patterns shifted by one element or one byte separate segment alignment from element alignment. Zero masks, the unsupported size code and a held output under back-pressure cover the remaining edges of the result and the handshake.

// File: rtl/hwc_pkg.sv
package hwc_pkg;
  typedef enum logic [1:0] {
    SZ_W4  = 2'd0,
    SZ_W8  = 2'd1,
    SZ_W16 = 2'd2,
    SZ_BAD = 2'd3
  } size_e;

  // log2 of the element size in bytes
  function automatic logic [2:0] elem_shift(input logic [1:0] code);
    return 3'd2 + {1'b0, code};
  endfunction

  function automatic logic size_supported(input logic [1:0] code);
    return code != SZ_BAD;
  endfunction
endpackage

// File: rtl/hwc_lead_pick.sv
module hwc_lead_pick #(
  parameter int LANES = 16,
  localparam int IW = $clog2(LANES)
) (
  input  logic [LANES-1:0] mask,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    idx = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (mask[k]) idx = IW'(k);
    end
  end
  assign any = |mask;
endmodule

// File: rtl/hwc_lane_match.sv
module hwc_lane_match #(
  parameter int LANES = 16,
  parameter int AW    = 32
) (
  input  logic [LANES*AW-1:0] addr,
  input  logic [LANES-1:0]    mask,
  input  logic [AW-1:0]       base,
  input  logic [2:0]          shift,
  output logic                all_ok
);
  logic [LANES-1:0] lane_ok;
  logic [AW-1:0]    elem_mask;

  assign elem_mask = (AW'(1) << shift) - AW'(1);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [AW-1:0] lane_addr;
    logic [AW-1:0] slot_addr;
    logic          in_slot;
    logic          elem_al;
    assign lane_addr = addr[k*AW +: AW];
    assign slot_addr = base + (AW'(k) << shift);
    assign in_slot   = (lane_addr == slot_addr);
    assign elem_al   = ((lane_addr & elem_mask) == '0);
    assign lane_ok[k] = !mask[k] || (in_slot && elem_al);
  end

  assign all_ok = &lane_ok;
endmodule

// File: rtl/hwc_out_reg.sv
module hwc_out_reg #(
  parameter int AW = 32,
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          d_coal,
  input  logic          d_fb,
  input  logic [AW-1:0] d_base,
  input  logic [TW-1:0] d_bytes,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          q_coal,
  output logic          q_fb,
  output logic [AW-1:0] q_base,
  output logic [TW-1:0] q_bytes
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q_coal    <= 1'b0;
      q_fb      <= 1'b0;
      q_base    <= '0;
      q_bytes   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        q_coal  <= d_coal;
        q_fb    <= d_fb;
        q_base  <= d_base;
        q_bytes <= d_bytes;
      end
    end
  end
endmodule

// File: rtl/hw_coalesce_check.sv
module hw_coalesce_check #(
  parameter int LANES = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(LANES),
  localparam int TW   = $clog2(LANES) + 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*AW-1:0] in_addr,
  input  logic [LANES-1:0]    in_mask,
  input  logic [1:0]          in_size,
  output logic                out_valid,
  input  logic                out_ready,
  output logic                out_coalesced,
  output logic                out_fallback,
  output logic [AW-1:0]       out_base,
  output logic [TW-1:0]       out_bytes
);
  import hwc_pkg::*;

  logic [2:0]    shift;
  logic          size_ok;
  logic          any_act;
  logic [IW-1:0] lead;
  logic [AW-1:0] lead_addr;
  logic [AW-1:0] base_c;
  logic [AW-1:0] seg_mask;
  logic          base_al;
  logic          lanes_ok;
  logic          coal_c;
  logic          fb_c;
  logic [AW-1:0] base_o;
  logic [TW-1:0] bytes_o;

  assign shift   = elem_shift(in_size);
  assign size_ok = size_supported(in_size);

  hwc_lead_pick #(.LANES(LANES)) u_lead (
    .mask (in_mask),
    .any  (any_act),
    .idx  (lead)
  );

  assign lead_addr = in_addr[int'(lead)*AW +: AW];
  assign base_c    = lead_addr - (AW'(lead) << shift);
  assign seg_mask  = (AW'(LANES) << shift) - AW'(1);
  assign base_al   = ((base_c & seg_mask) == '0);

  hwc_lane_match #(.LANES(LANES), .AW(AW)) u_match (
    .addr   (in_addr),
    .mask   (in_mask),
    .base   (base_c),
    .shift  (shift),
    .all_ok (lanes_ok)
  );

  assign coal_c  = any_act && size_ok && base_al && lanes_ok;
  assign fb_c    = any_act && !coal_c;
  assign base_o  = coal_c ? base_c : '0;
  assign bytes_o = coal_c ? (TW'(LANES) << shift) : '0;

  hwc_out_reg #(.AW(AW), .TW(TW)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_coal    (coal_c),
    .d_fb      (fb_c),
    .d_base    (base_o),
    .d_bytes   (bytes_o),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_coal    (out_coalesced),
    .q_fb      (out_fallback),
    .q_base    (out_base),
    .q_bytes   (out_bytes)
  );
endmodule

// File: rtl/hwc_check.sv
module hwc_check #(
  parameter int AW = 32,
  parameter int TW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_coalesced,
  input logic          out_fallback,
  input logic [AW-1:0] out_base,
  input logic [TW-1:0] out_bytes
);
  // R8: accepted request shows up on the next edge
  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R8: stalled result holds steady
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_coalesced) &&
      $stable(out_fallback) && $stable(out_base) && $stable(out_bytes));

  // R8: no new request taken while stalled
  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R5: verdicts exclusive
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_coalesced && out_fallback));

  // R2: transaction size is a power of two
  p_bytes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_coalesced |-> $countones(out_bytes) == 1);

  // R3: base aligned to transaction size
  p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_coalesced |->
      (out_base & (AW'(out_bytes) - AW'(1))) == '0);

  // R7: no transaction reported when not coalesced
  p_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_coalesced |-> out_bytes == '0 && out_base == '0);
endmodule

bind hw_coalesce_check hwc_check #(.AW(AW), .TW(TW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_coalesced (out_coalesced),
  .out_fallback  (out_fallback),
  .out_base      (out_base),
  .out_bytes     (out_bytes)
);

// File: tb/tb_hw_coalesce_check.sv
module tb_hw_coalesce_check;
  localparam int LANES = 16;
  localparam int AW    = 32;
  localparam int TW    = 9;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                in_valid = 1'b0;
  logic                in_ready;
  logic [LANES*AW-1:0] in_addr = '0;
  logic [LANES-1:0]    in_mask = '0;
  logic [1:0]          in_size = '0;
  logic                out_valid;
  logic                out_ready = 1'b1;
  logic                out_coalesced;
  logic                out_fallback;
  logic [AW-1:0]       out_base;
  logic [TW-1:0]       out_bytes;

  int total = 0;
  int bad = 0;
  logic [31:0] a [LANES];

  always #2.5 clk = ~clk;

  hw_coalesce_check dut (.*);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference: segment found by masking the lead address
  task automatic model(input logic [1:0] sz, input logic [15:0] m,
                       output logic c, output logic f,
                       output logic [31:0] b, output logic [8:0] n);
    int esz, seg, lead;
    logic [31:0] bb;
    logic ok;
    c = 0; f = 0; b = 0; n = 0;
    if (m == 0) return;
    if (sz == 2'd3) begin f = 1; return; end
    esz = 4 << sz;
    seg = 16 * esz;
    lead = 0;
    for (int k = LANES - 1; k >= 0; k--) if (m[k]) lead = k;
    bb = a[lead] & ~(32'(seg) - 1);
    ok = 1;
    for (int k = 0; k < LANES; k++)
      if (m[k] && a[k] != bb + 32'(k * esz)) ok = 0;
    c = ok; f = !ok;
    b = ok ? bb : 0;
    n = ok ? 9'(seg) : 0;
  endtask

  task automatic run(input string req, input logic [1:0] sz, input logic [15:0] m);
    logic c, f;
    logic [31:0] b;
    logic [8:0] n;
    model(sz, m, c, f, b, n);
    for (int k = 0; k < LANES; k++) in_addr[k*AW +: AW] = a[k];
    in_mask = m; in_size = sz; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, "out_valid", out_valid, 1);
    chk(req, "coalesced", out_coalesced, c);
    chk(req, "fallback", out_fallback, f);
    chk(req, "base", out_base, b);
    chk(req, "bytes", out_bytes, n);
  endtask

  // fill a perfect pattern; inactive lanes get junk (R4)
  task automatic fill(input logic [31:0] base, input int esz, input logic [15:0] m);
    for (int k = 0; k < LANES; k++)
      a[k] = m[k] ? base + 32'(k * esz) : $urandom;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] masks [8];
    logic [31:0] bases [3];
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    masks[0] = 16'hFFFF; masks[1] = 16'h0001; masks[2] = 16'h8000;
    masks[3] = 16'hAAAA; masks[4] = 16'h5555; masks[5] = 16'h0FF0;
    masks[6] = 16'($urandom) | 16'h0100; masks[7] = 16'hF00F;
    bases[0] = 32'h0; bases[1] = 32'h0001_0000; bases[2] = 32'hFFFF_F000;

    for (int sz = 0; sz < 3; sz++) begin
      int esz;
      esz = 4 << sz;
      for (int bi = 0; bi < 3; bi++) begin
        for (int mi = 0; mi < 8; mi++) begin
          logic [15:0] m;
          int lo, hi;
          m = masks[mi];
          lo = 0; hi = 0;
          for (int k = LANES - 1; k >= 0; k--) if (m[k]) lo = k;
          for (int k = 0; k < LANES; k++) if (m[k]) hi = k;
          // R2 R3 R4: perfect lane order, junk in idle lanes
          fill(bases[bi], esz, m);
          run("R3", 2'(sz), m);
          // R5: highest active lane moved one element
          fill(bases[bi], esz, m);
          a[hi] = a[hi] + 32'(esz);
          run("R5", 2'(sz), m);
          // R5: swap two active lanes
          if (lo != hi) begin
            logic [31:0] t;
            fill(bases[bi], esz, m);
            t = a[lo]; a[lo] = a[hi]; a[hi] = t;
            run("R5", 2'(sz), m);
          end
          // R5: broadcast of one word
          if (lo != hi) begin
            for (int k = 0; k < LANES; k++) a[k] = bases[bi];
            run("R5", 2'(sz), m);
          end
          // R6: segment off by one element
          fill(bases[bi] + 32'(esz), esz, m);
          run("R6", 2'(sz), m);
          // R6: element misaligned by one byte
          fill(bases[bi] + 32'd1, esz, m);
          run("R6", 2'(sz), m);
        end
        // R3: every single lane alone, at its slot
        for (int k = 0; k < LANES; k++) begin
          fill(bases[bi], esz, 16'(1) << k);
          run("R3", 2'(sz), 16'(1) << k);
        end
      end
      // R7: empty mask
      fill(32'h40, esz, 16'h0);
      run("R7", 2'(sz), 16'h0);
    end

    // R2: unsupported size code
    fill(32'h0, 16, 16'hFFFF);
    run("R2", 2'd3, 16'hFFFF);
    run("R2", 2'd3, 16'h0);

    // R8: one-cycle valid, then drops
    @(negedge clk);
    chk("R8", "out_valid drop", out_valid, 0);

    // R8: back-pressure
    out_ready = 1'b0;
    fill(32'h0000_2000, 4, 16'hFFFF);
    run("R8", 2'd0, 16'hFFFF);
    chk("R8", "in_ready stalled", in_ready, 0);
    fill(32'h0, 8, 16'hFFFF);
    for (int k = 0; k < LANES; k++) in_addr[k*AW +: AW] = a[k];
    in_size = 2'd1; in_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "held valid", out_valid, 1);
    chk("R8", "held base", out_base, 32'h0000_2000);
    chk("R8", "held bytes", out_bytes, 64);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8", "drained", out_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule